// File: doc/BRIEF.md
# Interface-Bus Response Frame Generator

This block forms the reply a remote terminal sends back on the response bus once it has been interrogated. An upstream decoder hands it one command at a time. Each command carries an acquisition flag, a width flag and an address. The address is a memory-load address or, for mode commands, a channel address, and it is latched and presented to the subsystem. A command that needs no data is answered with a fixed acknowledgement of thirteen zero bits. An acquisition command first starts the external converter. The block then waits for the conversion to finish and frames either the low 8 or all 16 sample bits into the reply.

The reply leaves as a serial bit stream, most significant bit first. A bit strobe from the line codec moves it on by one bit. A single-cycle done pulse closes the frame. Every frame has the same layout: a 3-bit header (`101` for data, `000` for the acknowledgement), the data field, an even-parity bit over the data, and a final zero. A data frame is 13 bits long for 8-bit data and 21 bits long for 16-bit data. If the converter does not answer within a programmable number of cycles, the block falls back to the acknowledgement frame and raises a timeout flag.

Top module: `resp_frame_gen`

## Requirements
- R1: A command with `cmd_acq`=0 is answered with a 13-bit frame of all zeros, and `adc_start` stays low.
- R2: An acquisition command with `cmd_wide`=0 is answered with a 13-bit frame, sent in order: `1`,`0`,`1`, then `adc_data[7:0]` MSB first, then the XOR of those 8 bits, then `0`.
- R3: An acquisition command with `cmd_wide`=1 is answered with a 21-bit frame, sent in order: `1`,`0`,`1`, then `adc_data[15:0]` MSB first, then the XOR of those 16 bits, then `0`.
- R4: `adc_start` is high for exactly one cycle, in the cycle after an acquisition command is accepted.
- R5: `tx_active` stays low until `adc_done` has been sampled high. The first frame bit is on `tx_bit` in the cycle after that.
- R6: Suppose `adc_done` is not sampled high during the first `tmo_limit` cycles after `adc_start`. The block then sends the R1 acknowledgement frame and sets `tmo_flag`. `tmo_flag` stays set until the next command is accepted. A done that arrives in the last cycle of that window still gives a data frame.
- R7: `addr_out` takes `cmd_addr` on acceptance and holds it until the next acceptance.
- R8: `tx_bit` advances by one bit only on a cycle with `bit_strobe` high while `tx_active` is high, and holds otherwise.
- R9: `tx_done` is high for exactly one cycle, in the cycle after the strobe that consumed the last bit. `tx_active` is low in that cycle.
- R10: `cmd_ready` is low from acceptance through the `tx_done` cycle. A `cmd_valid` during that time is ignored.
- R11: After reset, `cmd_ready`=1 and `tx_active`, `tx_done`, `adc_start`, `tmo_flag` and `tx_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Decoded command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_acq | input | 1 | Command requires data acquisition |
| cmd_wide | input | 1 | 16-bit data (1) or 8-bit data (0) |
| cmd_addr | input | ADDR_W | Memory-load or channel address |
| addr_out | output | ADDR_W | Latched address toward the subsystem |
| adc_start | output | 1 | Conversion start pulse |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | 16 | Converter result |
| tmo_limit | input | TMO_W | Conversion wait limit in cycles |
| tmo_flag | output | 1 | Last acquisition timed out |
| bit_strobe | input | 1 | Line codec takes the current bit |
| tx_bit | output | 1 | Current frame bit |
| tx_active | output | 1 | Frame transmission in progress |
| tx_done | output | 1 | Frame finished pulse |

## Verification
A corrupted shift register or bit counter shows up as a wrong bit, or a wrong frame length, within the frame being sent. It is therefore seen no later than the `tx_done` pulse, which would then arrive early, late or never. A wrong latched width flag swaps the 13-bit and 21-bit layouts, so the header and parity positions land in the wrong places. A stuck wait counter shows up after at most `tmo_limit` cycles: the reply is an acknowledgement where data was expected, or the reverse, and `tmo_flag` takes the wrong value. Random strobe gaps expose any shift that happens without a strobe.

// File: rtl/resp_frame_gen.sv
module resp_frame_gen #(
  parameter int ADDR_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_acq,
  input  logic              cmd_wide,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic              adc_start,
  input  logic              adc_done,
  input  logic [15:0]       adc_data,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              tmo_flag,
  input  logic              bit_strobe,
  output logic              tx_bit,
  output logic              tx_active,
  output logic              tx_done
);
  localparam int FW = 21;
  localparam int CW = 5;
  localparam logic [CW-1:0] LAST_N = CW'(12);
  localparam logic [CW-1:0] LAST_W = CW'(20);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_SEND, S_DONE} st_t;
  st_t st;

  logic [FW-1:0]     sreg;
  logic [CW-1:0]     bcnt, last;
  logic [TMO_W-1:0]  cnt;
  logic              wide_q;
  logic              timeout;

  function automatic logic [FW-1:0] data_frame(input logic wide, input logic [15:0] d);
    if (wide) return {3'b101, d, ^d, 1'b0};
    else      return {3'b101, d[7:0], ^d[7:0], 1'b0, 8'b0};
  endfunction

  assign cmd_ready = (st == S_IDLE);
  assign tx_active = (st == S_SEND);
  assign tx_done   = (st == S_DONE);
  assign tx_bit    = tx_active & sreg[FW-1];
  assign timeout   = ({1'b0, cnt} + 1'b1) >= {1'b0, tmo_limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sreg      <= '0;
      bcnt      <= '0;
      last      <= LAST_N;
      cnt       <= '0;
      wide_q    <= 1'b0;
      adc_start <= 1'b0;
      tmo_flag  <= 1'b0;
      addr_out  <= '0;
    end else begin
      adc_start <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          addr_out <= cmd_addr;
          tmo_flag <= 1'b0;
          wide_q   <= cmd_wide;
          bcnt     <= '0;
          if (cmd_acq) begin
            adc_start <= 1'b1;
            cnt       <= '0;
            st        <= S_CONV;
          end else begin
            sreg <= '0;
            last <= LAST_N;
            st   <= S_SEND;
          end
        end
        S_CONV: begin
          if (adc_done) begin
            sreg <= data_frame(wide_q, adc_data);
            last <= wide_q ? LAST_W : LAST_N;
            st   <= S_SEND;
          end else if (timeout) begin
            sreg     <= '0;
            last     <= LAST_N;
            tmo_flag <= 1'b1;
            st       <= S_SEND;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SEND: if (bit_strobe) begin
          if (bcnt == last) st <= S_DONE;
          else begin
            sreg <= sreg << 1;
            bcnt <= bcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  adc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(cmd_valid && cmd_ready && cmd_acq));

  // R4
  adc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R8
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !bit_strobe) |=> (tx_active && $stable(tx_bit)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (!tx_done && cmd_ready));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> $stable(addr_out));

  // R6
  tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (tx_active && !$past(adc_done)));

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active || adc_start) |-> !cmd_ready);
endmodule

// File: tb/resp_frame_gen_tb.sv
module resp_frame_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_acq = 1'b0, cmd_wide = 1'b0;
  logic [7:0]  cmd_addr = '0;
  logic        adc_done = 1'b0;
  logic [15:0] adc_data = '0;
  logic [15:0] tmo_limit = 16'd4;
  logic        bit_strobe = 1'b0;
  logic        cmd_ready, adc_start, tmo_flag, tx_bit, tx_active, tx_done;
  logic [7:0]  addr_out;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  resp_frame_gen #(.ADDR_W(8), .TMO_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_acq(cmd_acq), .cmd_wide(cmd_wide), .cmd_addr(cmd_addr), .addr_out(addr_out),
    .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
    .tmo_limit(tmo_limit), .tmo_flag(tmo_flag), .bit_strobe(bit_strobe),
    .tx_bit(tx_bit), .tx_active(tx_active), .tx_done(tx_done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [20:0] exp_frame(input bit data_ok, input bit wide, input logic [15:0] d);
    if (!data_ok) return '0;
    if (wide) return {3'b101, d, ^d, 1'b0};
    return {3'b101, d[7:0], ^d[7:0], 1'b0, 8'b0};
  endfunction

  function automatic int exp_len(input bit data_ok, input bit wide);
    return (data_ok && wide) ? 21 : 13;
  endfunction

  task automatic run_cmd(input bit acq, input bit wide, input logic [7:0] addr,
                         input logic [15:0] data, input int done_at, input logic [15:0] lim);
    bit to;
    int stop;
    int len;
    logic [20:0] exp;
    logic [20:0] got;
    string rq;
    to   = acq && (done_at > int'(lim));
    len  = exp_len(acq && !to, wide);
    exp  = exp_frame(acq && !to, wide, data);
    rq   = !acq ? "R1" : to ? "R6" : wide ? "R3" : "R2";
    got  = '0;
    @(negedge clk);
    tmo_limit = lim;
    chk(cmd_ready === 1'b1, "R10 ready before cmd", 32'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_acq = acq; cmd_wide = wide; cmd_addr = addr;
    @(negedge clk);
    cmd_acq = $urandom % 2; cmd_wide = $urandom % 2; cmd_addr = ~addr;
    chk(addr_out === addr, "R7 addr latched", 32'(addr_out), 32'(addr));
    chk(adc_start === acq, "R4 adc_start pulse", 32'(adc_start), 32'(acq));
    chk(cmd_ready === 1'b0, "R10 ready low after accept", 32'(cmd_ready), 0);
    if (acq) begin
      stop = to ? int'(lim) : done_at;
      for (int j = 1; j <= stop; j++) begin
        chk(tx_active === 1'b0, "R5 no tx before done", 32'(tx_active), 0);
        if (j == done_at) begin adc_done = 1'b1; adc_data = data; end
        else adc_data = 16'($urandom);
        @(negedge clk);
        adc_done = 1'b0;
        if (j == 1) chk(adc_start === 1'b0, "R4 adc_start single cycle", 32'(adc_start), 0);
      end
    end
    chk(tx_active === 1'b1, "R5 tx starts", 32'(tx_active), 1);
    chk(tmo_flag === to, "R6 timeout flag", 32'(tmo_flag), 32'(to));
    for (int i = 0; i < len; i++) begin
      got[20-i] = tx_bit;
      for (int g = 0; g < int'($urandom % 3); g++) begin
        @(negedge clk);
        if (tx_bit !== got[20-i])
          chk(1'b0, "R8 bit held without strobe", 32'(tx_bit), 32'(got[20-i]));
      end
      bit_strobe = 1'b1;
      @(negedge clk);
      bit_strobe = 1'b0;
      if (i < len - 1) chk(tx_active === 1'b1, "R8 still active", 32'(tx_active), 1);
    end
    chk(got === exp, {rq, " frame content"}, 32'(got), 32'(exp));
    chk(tx_done === 1'b1 && tx_active === 1'b0, "R9 done after last bit", {tx_done, tx_active}, 2'b10);
    chk(cmd_ready === 1'b0, "R10 ready low in done cycle", 32'(cmd_ready), 0);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(tx_done === 1'b0 && cmd_ready === 1'b1, "R9 done single cycle", {tx_done, cmd_ready}, 2'b01);
    chk(addr_out === addr, "R10 ignored cmd kept addr", 32'(addr_out), 32'(addr));
    chk(tmo_flag === to, "R6 flag held", 32'(tmo_flag), 32'(to));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready === 1'b1 && tx_active === 1'b0 && tx_done === 1'b0 && adc_start === 1'b0
        && tmo_flag === 1'b0 && tx_bit === 1'b0, "R11 reset state",
        {cmd_ready, tx_active, tx_done, adc_start, tmo_flag, tx_bit}, 6'b100000);
    rst_n = 1'b1;
    void'($urandom(32'd2024));
    // R1 acknowledgement, wide flag irrelevant
    run_cmd(1'b0, 1'b0, 8'h11, 16'hFFFF, 0, 16'd4);
    run_cmd(1'b0, 1'b1, 8'h22, 16'hFFFF, 0, 16'd4);
    // R2 / R3 directed patterns
    run_cmd(1'b1, 1'b0, 8'h33, 16'h00A5, 1, 16'd4);
    run_cmd(1'b1, 1'b1, 8'h44, 16'hFFFF, 2, 16'd4);
    run_cmd(1'b1, 1'b1, 8'h55, 16'h8001, 3, 16'd4);
    // R6 boundary: done in last cycle of window, then one too late
    run_cmd(1'b1, 1'b1, 8'h66, 16'h1234, 5, 16'd5);
    run_cmd(1'b1, 1'b0, 8'h77, 16'h00FF, 6, 16'd5);
    // R6 flag cleared by next accepted command
    run_cmd(1'b0, 1'b0, 8'h88, 16'h0, 0, 16'd5);
    run_cmd(1'b1, 1'b1, 8'h99, 16'hBEEF, 9, 16'd1);
    run_cmd(1'b1, 1'b0, 8'hAA, 16'h0081, 1, 16'd1);
    for (int n = 0; n < 40; n++) begin
      logic [15:0] lim;
      lim = 16'(1 + $urandom % 6);
      run_cmd(1'($urandom % 4 != 0), 1'($urandom % 2), 8'($urandom), 16'($urandom),
              int'(1 + $urandom % 8), lim);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got=hang exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule